// File: doc/BRIEF.md
# DAC Waveform Playback Sequencer

This block drives the 8-bit parallel write bus of an external 12-bit voltage DAC. It replays a short waveform held on chip at a fixed sample rate. Right after reset it issues a single configuration write. From then on, each time its sample divider fires while playback is enabled, it moves one 12-bit sample to the converter. A sample goes out as two byte writes, upper byte first and lower byte second. A low pulse on the load strobe then transfers the new code to the analog output.

The waveform table holds 64 bytes, stored as 32 pairs. Within a pair the even byte is the upper part of the sample and the odd byte is the lower part. Software fills the table through a plain byte write port. That port has no back-pressure: every write is taken on the clock edge where it is presented.

Every bus timing minimum is a nanosecond parameter. Each one is turned into a whole number of clock cycles by rounding up. The covered minimums are chip-select lead time, data and address setup, hold, strobe high time, the gap before the load strobe and the load pulse width. A divider tick that lands while a transfer is still running is discarded and sets a sticky overrun flag.

Top module: `wp_dac_player`

## Requirements
- R1: After reset, and before any sample, the block performs exactly one bus write of value 0x11 to bus address 3. This is the configuration write.
- R2: Table byte address 2k holds the upper part of sample k and byte address 2k+1 holds the lower part. A table write is taken on every clock edge where the write enable is high.
- R3: Each sample is sent as three steps in a fixed order. First comes a write to bus address 1 carrying the upper byte with bits 7:4 forced to 0. Second comes a write to bus address 0 carrying the lower byte. Third comes one low pulse on the load strobe. The load strobe never falls at any other point.
- R4: The sample pointer steps by one pair (two bytes) per sample and wraps from pair 31 back to pair 0.
- R5: While playback is enabled, a new sample starts every SAMPLE_PERIOD_NS / CLK_PERIOD_NS cycles. While it is disabled, the divider is held clear and no new sample starts.
- R6: Chip select is low for at least ceil(15 ns) of cycles before the write strobe falls. The write strobe is only low while chip select is low.
- R7: Bus address and data do not change while chip select stays low. This gives at least ceil(20 ns) of address setup, ceil(10 ns) of data setup and ceil(5 ns) of hold around the write strobe's rising edge.
- R8: The write strobe stays high for at least ceil(20 ns) of cycles between strobes.
- R9: The load strobe falls at least ceil(5 ns) of cycles after the last write strobe rising edge. It then stays low for at least ceil(23 ns) of cycles.
- R10: A divider tick that arrives while a configuration or sample transfer is in progress starts no transfer. It sets the overrun output, which stays high until reset.
- R11: While reset is held, chip select, write strobe and load strobe are high and overrun is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| play_en | input | 1 | Enables the sample divider |
| tbl_wr_en | input | 1 | Table byte write enable |
| tbl_wr_addr | input | TBL_AW | Table byte address |
| tbl_wr_data | input | 8 | Table byte value |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_we_n | output | 1 | Write strobe, active low; data is taken on its rising edge |
| dac_addr | output | 2 | Register address on the DAC bus |
| dac_data | output | 8 | Data byte on the DAC bus |
| dac_ld_n | output | 1 | Load strobe, active low |
| overrun | output | 1 | Sticky flag for a dropped tick |

## Verification
The bound checker checks the bus-level properties on every cycle:
- chip-select lead time before each strobe;
- a stable address and data for the whole chip-select window;
- strobe high time;
- the delay and width of the load pulse;
- the fact that each load pulse directly follows an upper-byte write and then a lower-byte write;
- the stickiness of overrun.

Only the bench's scenarios can show the remaining behaviour:
- the single configuration word;
- the exact byte values taken from the table, including the masked upper nibble;
- pointer wrap after 32 samples;
- the exact sample period;
- silence while playback is disabled;
- the halved sample rate that a too-long transfer produces.

// File: rtl/wp_pkg.sv
package wp_pkg;

  // nanoseconds to whole cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int per_ns);
    int c;
    c = (ns + per_ns - 1) / per_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam logic [1:0] BUS_A_LOW  = 2'd0;
  localparam logic [1:0] BUS_A_HIGH = 2'd1;
  localparam logic [1:0] BUS_A_CFG  = 2'd3;
  localparam logic [7:0] CFG_WORD   = 8'h11;

  typedef struct packed {
    logic [1:0] addr;
    logic [7:0] data;
  } bus_req_t;

  typedef enum logic [2:0] {
    W_IDLE, W_SETUP, W_STROBE, W_HOLD, W_REC
  } wr_st_e;

  typedef enum logic [3:0] {
    S_CFG, S_CFG_WAIT, S_IDLE, S_HI, S_HI_WAIT, S_LO, S_LO_WAIT, S_LD_DLY, S_LD_LOW
  } seq_st_e;

endpackage

// File: rtl/wp_tick_div.sv
module wp_tick_div #(
  parameter int DIV = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (!en)         cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/wp_table.sv
module wp_table #(
  parameter int BYTES = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-2:0] pair_idx,
  output logic [7:0]    hi_byte,
  output logic [7:0]    lo_byte
);
  logic [7:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign hi_byte = mem[{pair_idx, 1'b0}];
  assign lo_byte = mem[{pair_idx, 1'b1}];
endmodule

// File: rtl/wp_bus_writer.sv
module wp_bus_writer import wp_pkg::*; #(
  parameter int CS_SU  = 2,
  parameter int STROBE = 2,
  parameter int HOLD   = 1,
  parameter int REC    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  bus_req_t   req,
  output logic       req_ready,
  output logic       done,
  output logic       cs_n,
  output logic       we_n,
  output logic [1:0] addr,
  output logic [7:0] data
);
  localparam int CNT_W = 16;

  wr_st_e           st;
  logic [CNT_W-1:0] cnt;

  assign req_ready = (st == W_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= W_IDLE;
      cnt  <= '0;
      done <= 1'b0;
      cs_n <= 1'b1;
      we_n <= 1'b1;
      addr <= '0;
      data <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        W_IDLE: if (req_valid) begin
          st   <= W_SETUP;
          cnt  <= CNT_W'(CS_SU - 1);
          cs_n <= 1'b0;
          addr <= req.addr;
          data <= req.data;
        end
        W_SETUP: if (cnt == '0) begin
          st   <= W_STROBE;
          cnt  <= CNT_W'(STROBE - 1);
          we_n <= 1'b0;
        end else cnt <= cnt - 1'b1;
        W_STROBE: if (cnt == '0) begin
          st   <= W_HOLD;
          cnt  <= CNT_W'(HOLD - 1);
          we_n <= 1'b1;
        end else cnt <= cnt - 1'b1;
        W_HOLD: if (cnt == '0) begin
          st   <= W_REC;
          cnt  <= CNT_W'(REC - 1);
          cs_n <= 1'b1;
        end else cnt <= cnt - 1'b1;
        W_REC: if (cnt == '0) begin
          st   <= W_IDLE;
          done <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wp_seq.sv
module wp_seq import wp_pkg::*; #(
  parameter int AW          = 6,
  parameter int SAMPLE_BITS = 12,
  parameter int LD_DLY      = 1,
  parameter int LD_LOW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [7:0]    hi_byte,
  input  logic [7:0]    lo_byte,
  output logic [AW-2:0] pair_idx,
  output logic          req_valid,
  output bus_req_t      req,
  input  logic          req_ready,
  input  logic          wr_done,
  output logic          ld_n,
  output logic          overrun
);
  localparam int HI_KEEP = SAMPLE_BITS - 8;
  localparam logic [7:0] HI_MASK = 8'((1 << HI_KEEP) - 1);
  localparam int CNT_W = 16;

  seq_st_e          st;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    req_valid = 1'b0;
    req       = '0;
    unique case (st)
      S_CFG: begin
        req_valid = 1'b1;
        req       = '{addr: BUS_A_CFG, data: CFG_WORD};
      end
      S_HI: begin
        req_valid = 1'b1;
        req       = '{addr: BUS_A_HIGH, data: hi_byte & HI_MASK};
      end
      S_LO: begin
        req_valid = 1'b1;
        req       = '{addr: BUS_A_LOW, data: lo_byte};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_CFG;
      cnt      <= '0;
      ld_n     <= 1'b1;
      pair_idx <= '0;
      overrun  <= 1'b0;
    end else begin
      if (tick && st != S_IDLE) overrun <= 1'b1;
      unique case (st)
        S_CFG:      if (req_ready) st <= S_CFG_WAIT;
        S_CFG_WAIT: if (wr_done) st <= S_IDLE;
        S_IDLE:     if (tick) st <= S_HI;
        S_HI:       if (req_ready) st <= S_HI_WAIT;
        S_HI_WAIT:  if (wr_done) st <= S_LO;
        S_LO:       if (req_ready) st <= S_LO_WAIT;
        S_LO_WAIT:  if (wr_done) begin
          st  <= S_LD_DLY;
          cnt <= CNT_W'(LD_DLY - 1);
        end
        S_LD_DLY: if (cnt == '0) begin
          st   <= S_LD_LOW;
          cnt  <= CNT_W'(LD_LOW - 1);
          ld_n <= 1'b0;
        end else cnt <= cnt - 1'b1;
        S_LD_LOW: if (cnt == '0) begin
          st       <= S_IDLE;
          ld_n     <= 1'b1;
          pair_idx <= pair_idx + 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wp_dac_player.sv
module wp_dac_player import wp_pkg::*; #(
  parameter int CLK_PERIOD_NS    = 10,
  parameter int SAMPLE_PERIOD_NS = 50000,
  parameter int TBL_BYTES        = 64,
  parameter int SAMPLE_BITS      = 12,
  parameter int CS_SU_NS         = 15,
  parameter int D_SU_NS          = 10,
  parameter int A_SU_NS          = 20,
  parameter int HOLD_NS          = 5,
  parameter int WE_HI_NS         = 20,
  parameter int LD_DLY_NS        = 5,
  parameter int LD_LOW_NS        = 23,
  localparam int TBL_AW          = $clog2(TBL_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              play_en,
  input  logic              tbl_wr_en,
  input  logic [TBL_AW-1:0] tbl_wr_addr,
  input  logic [7:0]        tbl_wr_data,
  output logic              dac_cs_n,
  output logic              dac_we_n,
  output logic [1:0]        dac_addr,
  output logic [7:0]        dac_data,
  output logic              dac_ld_n,
  output logic              overrun
);
  localparam int DIV        = SAMPLE_PERIOD_NS / CLK_PERIOD_NS;
  localparam int CS_SU_CYC  = ns2cyc(CS_SU_NS, CLK_PERIOD_NS);
  localparam int STB_CYC    = imax(ns2cyc(D_SU_NS, CLK_PERIOD_NS), ns2cyc(A_SU_NS, CLK_PERIOD_NS));
  localparam int HOLD_CYC   = ns2cyc(HOLD_NS, CLK_PERIOD_NS);
  localparam int WE_HI_CYC  = ns2cyc(WE_HI_NS, CLK_PERIOD_NS);
  localparam int LD_DLY_CYC = ns2cyc(LD_DLY_NS, CLK_PERIOD_NS);
  localparam int LD_LOW_CYC = ns2cyc(LD_LOW_NS, CLK_PERIOD_NS);

  logic              tick;
  logic [TBL_AW-2:0] pair_idx;
  logic [7:0]        hi_byte, lo_byte;
  logic              req_valid, req_ready, wr_done;
  bus_req_t          req;

  wp_tick_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .en(play_en), .tick(tick)
  );

  wp_table #(.BYTES(TBL_BYTES), .AW(TBL_AW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_addr(tbl_wr_addr),
    .wr_data(tbl_wr_data), .pair_idx(pair_idx), .hi_byte(hi_byte), .lo_byte(lo_byte)
  );

  wp_seq #(.AW(TBL_AW), .SAMPLE_BITS(SAMPLE_BITS), .LD_DLY(LD_DLY_CYC), .LD_LOW(LD_LOW_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hi_byte(hi_byte), .lo_byte(lo_byte),
    .pair_idx(pair_idx), .req_valid(req_valid), .req(req), .req_ready(req_ready),
    .wr_done(wr_done), .ld_n(dac_ld_n), .overrun(overrun)
  );

  wp_bus_writer #(.CS_SU(CS_SU_CYC), .STROBE(STB_CYC), .HOLD(HOLD_CYC), .REC(WE_HI_CYC)) u_wr (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req(req), .req_ready(req_ready),
    .done(wr_done), .cs_n(dac_cs_n), .we_n(dac_we_n), .addr(dac_addr), .data(dac_data)
  );
endmodule

// File: rtl/wp_checker.sv
module wp_checker import wp_pkg::*; #(
  parameter int CS_SU  = 2,
  parameter int WE_HI  = 2,
  parameter int LD_DLY = 1,
  parameter int LD_LOW = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       we_n,
  input logic [1:0] addr,
  input logic [7:0] data,
  input logic       ld_n,
  input logic       overrun
);
  localparam int W = 16;
  localparam logic [W-1:0] SAT = '1;

  logic [W-1:0] cs_lo_cnt, we_hi_cnt, ld_lo_cnt;
  logic         we_q;
  logic [1:0]   last_a, prev_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_lo_cnt <= '0;
      we_hi_cnt <= SAT;
      ld_lo_cnt <= '0;
      we_q      <= 1'b1;
      last_a    <= 2'd2;
      prev_a    <= 2'd2;
    end else begin
      cs_lo_cnt <= cs_n ? '0 : ((cs_lo_cnt == SAT) ? SAT : cs_lo_cnt + 1'b1);
      we_hi_cnt <= !we_n ? '0 : ((we_hi_cnt == SAT) ? SAT : we_hi_cnt + 1'b1);
      ld_lo_cnt <= ld_n ? '0 : ((ld_lo_cnt == SAT) ? SAT : ld_lo_cnt + 1'b1);
      we_q      <= we_n;
      if (!we_n && we_q) begin
        prev_a <= last_a;
        last_a <= addr;
      end
    end
  end

  AST_CS_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> cs_lo_cnt >= W'(CS_SU)); // R6
  AST_WE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cs_n); // R6
  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> ($stable(addr) && $stable(data))); // R7
  AST_WE_HIGH_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> we_hi_cnt >= W'(WE_HI)); // R8
  AST_LD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ld_n) |-> (we_hi_cnt >= W'(LD_DLY) && cs_n)); // R9
  AST_LD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_n) |-> ld_lo_cnt >= W'(LD_LOW)); // R9
  AST_LD_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ld_n) |-> (last_a == BUS_A_LOW && prev_a == BUS_A_HIGH)); // R3
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R10
endmodule

bind wp_dac_player wp_checker #(
  .CS_SU(CS_SU_CYC), .WE_HI(WE_HI_CYC), .LD_DLY(LD_DLY_CYC), .LD_LOW(LD_LOW_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(dac_cs_n), .we_n(dac_we_n), .addr(dac_addr),
  .data(dac_data), .ld_n(dac_ld_n), .overrun(overrun)
);

// File: tb/sim_wp_dac_player.sv
`timescale 1ns/1ps
module sim_wp_dac_player;
  localparam int DIV = 50;
  localparam int SP  = DIV * 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0, play_en = 1'b0;
  logic       tbl_wr_en = 1'b0;
  logic [5:0] tbl_wr_addr = '0;
  logic [7:0] tbl_wr_data = '0;
  logic       cs_n, we_n, ld_n, ovr;
  logic [1:0] addr;
  logic [7:0] data;
  logic       cs1, we1, ld1, ovr1;
  logic [1:0] addr1;
  logic [7:0] data1;

  wp_dac_player #(.SAMPLE_PERIOD_NS(SP)) u0 (
    .clk(clk), .rst_n(rst_n), .play_en(play_en), .tbl_wr_en(tbl_wr_en),
    .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data), .dac_cs_n(cs_n),
    .dac_we_n(we_n), .dac_addr(addr), .dac_data(data), .dac_ld_n(ld_n), .overrun(ovr)
  );

  // long load pulse: transfer outlasts one divider period
  wp_dac_player #(.SAMPLE_PERIOD_NS(SP), .LD_LOW_NS(600)) u1 (
    .clk(clk), .rst_n(rst_n), .play_en(play_en), .tbl_wr_en(1'b0),
    .tbl_wr_addr(6'd0), .tbl_wr_data(8'd0), .dac_cs_n(cs1),
    .dac_we_n(we1), .dac_addr(addr1), .dac_data(data1), .dac_ld_n(ld1), .overrun(ovr1)
  );

  int total = 0, bad = 0;
  logic [7:0] model [64];

  function automatic logic [7:0] exp_hi(int k);
    return model[2 * (k % 32)] & 8'h0F;
  endfunction
  function automatic logic [7:0] exp_lo(int k);
    return model[2 * (k % 32) + 1];
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bus monitors
  logic mon_on = 1'b0;
  int nw = 0, nld = 0, nld1 = 0;
  logic [1:0] wa [512];
  logic [7:0] wd [512];
  realtime ld_t [128], ld_w [128], ld1_t [16];
  int ld_nw [128];
  realtime cs_fall_t = 0, we_rise_t = -1000, chg_t = 0;
  realtime min_cs = 1e9, min_su = 1e9, min_hold = 1e9, min_wehi = 1e9, min_lddly = 1e9;

  always @(addr or data) chg_t = $realtime;
  always @(negedge cs_n) if (mon_on) cs_fall_t = $realtime;
  always @(negedge we_n) if (mon_on) begin
    if ($realtime - cs_fall_t < min_cs) min_cs = $realtime - cs_fall_t;
    if ($realtime - we_rise_t < min_wehi) min_wehi = $realtime - we_rise_t;
  end
  always @(posedge we_n) if (mon_on) begin
    if ($realtime - chg_t < min_su) min_su = $realtime - chg_t;
    we_rise_t = $realtime;
    if (nw < 512) begin wa[nw] = addr; wd[nw] = data; end
    nw++;
  end
  always @(posedge cs_n) if (mon_on) begin
    if (chg_t > we_rise_t) min_hold = 0;
    else if ($realtime - we_rise_t < min_hold) min_hold = $realtime - we_rise_t;
  end
  always @(negedge ld_n) if (mon_on) begin
    if ($realtime - we_rise_t < min_lddly) min_lddly = $realtime - we_rise_t;
    if (nld < 128) begin ld_t[nld] = $realtime; ld_nw[nld] = nw; end
    nld++;
  end
  always @(posedge ld_n) if (mon_on && nld > 0 && nld <= 128)
    ld_w[nld-1] = $realtime - ld_t[nld-1];
  always @(negedge ld1) if (mon_on) begin
    if (nld1 < 16) ld1_t[nld1] = $realtime;
    nld1++;
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    mon_on = 1'b1;
    @(negedge clk);
    check("R11", "cs_n in reset", 32'(cs_n), 1);
    check("R11", "we_n in reset", 32'(we_n), 1);
    check("R11", "ld_n in reset", 32'(ld_n), 1);
    check("R11", "overrun in reset", 32'(ovr), 0);
    rst_n = 1'b1;

    // fill the table: random bytes plus directed corners
    for (int i = 0; i < 64; i++) model[i] = 8'($urandom);
    model[0] = 8'hFF; model[1] = 8'h00;
    model[62] = 8'hAB; model[63] = 8'hFF;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_addr = 6'(i); tbl_wr_data = model[i];
    end
    @(negedge clk); tbl_wr_en = 1'b0;
    repeat (20) @(negedge clk);

    check("R1", "writes before play", 32'(nw), 1);
    check("R1", "config address", 32'(wa[0]), 3);
    check("R1", "config value", 32'(wd[0]), 32'h11);
    check("R1", "load pulses before play", 32'(nld), 0);

    play_en = 1'b1;
    for (int i = 0; i < 5000 && nld < 40; i++) @(negedge clk);
    repeat (60) @(negedge clk);
    play_en = 1'b0;
    repeat (100) @(negedge clk);
    begin
      int snap_w, snap_l;
      snap_w = nw; snap_l = nld;
      repeat (400) @(negedge clk);
      check("R5", "writes while disabled", 32'(nw), 32'(snap_w));
      check("R5", "loads while disabled", 32'(nld), 32'(snap_l));
    end

    check("R1", "writes before first load", 32'(ld_nw[0]), 3);
    for (int k = 0; k < 40; k++) begin
      int ix;
      ix = ld_nw[k];
      check("R3", $sformatf("sample %0d first addr", k), 32'(wa[ix-2]), 1);
      check("R3", $sformatf("sample %0d upper byte", k), 32'(wd[ix-2]), 32'(exp_hi(k)));
      check("R3", $sformatf("sample %0d second addr", k), 32'(wa[ix-1]), 0);
      if (k >= 32)
        check("R4", $sformatf("wrapped sample %0d lower byte", k), 32'(wd[ix-1]), 32'(exp_lo(k)));
      else
        check("R2", $sformatf("sample %0d lower byte", k), 32'(wd[ix-1]), 32'(exp_lo(k)));
      if (k > 0) begin
        check("R3", $sformatf("writes per sample %0d", k), 32'(ld_nw[k] - ld_nw[k-1]), 2);
        check("R5", $sformatf("period before sample %0d", k), 32'(int'(ld_t[k] - ld_t[k-1])), 32'(SP));
      end
      check("R9", $sformatf("load width %0d", k), 32'(int'(ld_w[k])), 30);
    end

    check("R6", "cs lead >= 15ns", 32'(min_cs >= 15.0), 1);
    check("R7", "setup >= 20ns", 32'(min_su >= 20.0), 1);
    check("R7", "hold >= 5ns", 32'(min_hold >= 5.0), 1);
    check("R8", "we high >= 20ns", 32'(min_wehi >= 20.0), 1);
    check("R9", "load gap >= 5ns", 32'(min_lddly >= 5.0), 1);

    check("R10", "no overrun when fast enough", 32'(ovr), 0);
    check("R10", "overrun on slow transfer", 32'(ovr1), 1);
    for (int k = 1; k < 5; k++)
      check("R10", $sformatf("dropped tick period %0d", k), 32'(int'(ld1_t[k] - ld1_t[k-1])), 32'(2 * SP));

    summary();
  end
endmodule